// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two 64-bit event counters, an even one (index 0) and an odd one (index 1). Each counter has its own source select. It can count pulses on its own external event input, or counter-specific bits of a software-increment register write. The odd counter can also count overflows of the even counter, which joins the pair into one wider count. A control register holds a global enable, a self-clearing bit that zeroes both counters, and an overflow-width select. That select moves the overflow point from a carry out of bit 31 to a carry out of bit 63.

Software reaches the block through one register write port and one registered read port. Each counter has an enable bit, with separate set and clear registers. Each overflow sets a sticky status bit, which a write of one clears. Interrupt enables also have set and clear registers. A single level interrupt output is raised while any status bit is set and its enable bit is set. When 64-bit overflow is selected, chain counting is suppressed and the odd counter keeps its value.

Register map (4-bit address):
- 0: control
- 1: enable set
- 2: enable clear
- 3: overflow status
- 4: interrupt-enable set
- 5: interrupt-enable clear
- 6: software increment
- 7: even source
- 8: odd source
- 9: even counter value
- 10: odd counter value

Source codes:
- 0: external pulse
- 1: software increment
- 2: chain
- 3: no counting

Top module: `evt_pair_counter`

## Requirements
- R1: After reset both counters read 0, the status and enable registers read 0, irq is 0, and the control register reads 0x1040.
- R2: On read, control bit 6 is always 1 and bits 1 and 2 are always 0. Bits 15:11 hold the counter count, 2. Bit 0 (global enable) and bit 7 (64-bit overflow select) read back as written.
- R3: A control write with bit 1 set zeroes both counters on that clock edge.
- R4: A software-increment write with bit n set adds one to counter n only when three conditions hold: its source is 1, its enable bit is set, and control bit 0 is set. Otherwise the counter is unchanged.
- R5: With source 0 and both enables set, each cycle with evt_in[n] high adds one to counter n.
- R6: With control bit 7 clear, a carry out of bit 31 sets status bit n. The upper 32 bits still count, so 0xFFFFFFFF becomes 0x1_0000_0000.
- R7: With control bit 7 set, a carry out of bit 31 sets no status. Only a carry out of bit 63 does, and the counter wraps to 0.
- R8: With the odd source at 2 (chain) and control bit 7 clear, the odd counter adds one on each even-counter overflow. For example, 1 becomes 2.
- R9: In chain mode, an odd counter holding all ones wraps to 0 on an even overflow, and the status register reads 0x3.
- R10: With control bit 7 set, a chain-mode odd counter holds its value even when the even counter overflows.
- R11: Writing 1 to a status bit clears it. An overflow in the same cycle keeps that bit set.
- R12: irq is high exactly while some status bit and its interrupt-enable bit are both 1. Register 4 sets enable bits and register 5 clears them.
- R13: A register write to a counter takes priority over an increment of that counter in the same cycle.
- R14: Register 1 sets counter enable bits and register 2 clears them. Both read back the current enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Read data, registered, valid one cycle after rd_addr |
| evt_in | input | 2 | External event pulses, one per counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions watch properties that hold on every cycle:
- the fixed control readback fields
- zeroing of both counters after a counter-reset write
- counters frozen while the global enable is off
- a chain-mode odd counter frozen in 64-bit mode
- sticky status bits
- the interrupt level following status and enable

The overflow boundaries need preset values and exact increment counts, so only the bench scenarios can show them. These cover the carry at bit 31 against bit 63, chain increment and wrap with status 0x3, and write-over-increment priority.

// File: rtl/evp_pkg.sv
package evp_pkg;
  localparam int NUM_CNT = 2;

  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_CEN_SET = 4'd1,
    A_CEN_CLR = 4'd2,
    A_OVF     = 4'd3,
    A_IEN_SET = 4'd4,
    A_IEN_CLR = 4'd5,
    A_SWINC   = 4'd6,
    A_TYPE0   = 4'd7,
    A_TYPE1   = 4'd8,
    A_CNT0    = 4'd9,
    A_CNT1    = 4'd10
  } reg_addr_e;

  typedef enum logic [1:0] {
    EV_EXT   = 2'd0,
    EV_SW    = 2'd1,
    EV_CHAIN = 2'd2,
    EV_NONE  = 2'd3
  } evt_src_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CRST_BIT = 1;
  localparam int CTRL_RES1_BIT = 6;
  localparam int CTRL_LONG_BIT = 7;
  localparam int CTRL_N_LSB    = 11;
  localparam int CTRL_N_W      = 5;
endpackage

// File: rtl/evp_counter.sv
module evp_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             long_mode,
  output logic [CNT_W-1:0] value,
  output logic             ovf
);
  localparam int LOW_W = CNT_W / 2;

  logic inc_eff;

  // a write or reset in the same cycle wins over the increment
  always_comb begin
    inc_eff = inc && !clr && !load;
    ovf     = inc_eff && (long_mode ? (&value) : (&value[LOW_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (clr)     value <= '0;
    else if (load)    value <= load_val;
    else if (inc_eff) value <= value + 1'b1;
  end
endmodule

// File: rtl/evp_readmux.sv
module evp_readmux
  import evp_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      rd_addr,
  input  logic               gen_en,
  input  logic               long_mode,
  input  logic [NUM_CNT-1:0] cen,
  input  logic [NUM_CNT-1:0] ien,
  input  logic [NUM_CNT-1:0] ovf_st,
  input  logic [1:0]         src0,
  input  logic [1:0]         src1,
  input  logic [CNT_W-1:0]   cnt0,
  input  logic [CNT_W-1:0]   cnt1,
  output logic [CNT_W-1:0]   rd_data
);
  logic [CNT_W-1:0] rd_nx;

  always_comb begin
    rd_nx = '0;
    case (rd_addr)
      AW'(A_CTRL): begin
        rd_nx[CTRL_EN_BIT]                      = gen_en;
        rd_nx[CTRL_RES1_BIT]                    = 1'b1;
        rd_nx[CTRL_LONG_BIT]                    = long_mode;
        rd_nx[CTRL_N_LSB +: CTRL_N_W]           = CTRL_N_W'(NUM_CNT);
      end
      AW'(A_CEN_SET), AW'(A_CEN_CLR): rd_nx[NUM_CNT-1:0] = cen;
      AW'(A_IEN_SET), AW'(A_IEN_CLR): rd_nx[NUM_CNT-1:0] = ien;
      AW'(A_OVF):   rd_nx[NUM_CNT-1:0] = ovf_st;
      AW'(A_TYPE0): rd_nx[1:0] = src0;
      AW'(A_TYPE1): rd_nx[1:0] = src1;
      AW'(A_CNT0):  rd_nx = cnt0;
      AW'(A_CNT1):  rd_nx = cnt1;
      default:      rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end
endmodule

// File: rtl/evt_pair_counter.sv
module evt_pair_counter
  import evp_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [1:0]       evt_in,
  output logic             irq
);
  logic               gen_en, long_mode;
  logic [NUM_CNT-1:0] cen, ien, ovf_st;
  logic [1:0]         src [NUM_CNT];
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_ovf, cnt_inc, cnt_load, sw_pulse, active;
  logic [NUM_CNT-1:0] cen_nx, ien_nx, ovf_nx, w1c_mask;
  logic               wr_ctrl, cnt_rst;

  function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
    return wr_en && (a == AW'(r));
  endfunction

  always_comb begin
    wr_ctrl     = hit(wr_addr, A_CTRL);
    cnt_rst     = wr_ctrl && wr_data[CTRL_CRST_BIT];
    sw_pulse    = hit(wr_addr, A_SWINC) ? wr_data[NUM_CNT-1:0] : '0;
    cnt_load[0] = hit(wr_addr, A_CNT0);
    cnt_load[1] = hit(wr_addr, A_CNT1);
    w1c_mask    = hit(wr_addr, A_OVF) ? wr_data[NUM_CNT-1:0] : '0;
    active      = {NUM_CNT{gen_en}} & cen;
  end

  // even counter: external or software source only
  always_comb begin
    cnt_inc[0] = active[0] &&
                 ((src[0] == EV_EXT && evt_in[0]) || (src[0] == EV_SW && sw_pulse[0]));
    cnt_inc[1] = active[1] &&
                 ((src[1] == EV_EXT && evt_in[1]) || (src[1] == EV_SW && sw_pulse[1]) ||
                  (src[1] == EV_CHAIN && !long_mode && cnt_ovf[0]));
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    evp_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst      (rst),
      .clr      (cnt_rst),
      .load     (cnt_load[i]),
      .load_val (wr_data),
      .inc      (cnt_inc[i]),
      .long_mode(long_mode),
      .value    (cnt_val[i]),
      .ovf      (cnt_ovf[i])
    );
  end

  always_comb begin
    cen_nx = cen;
    if (hit(wr_addr, A_CEN_SET)) cen_nx = cen | wr_data[NUM_CNT-1:0];
    if (hit(wr_addr, A_CEN_CLR)) cen_nx = cen & ~wr_data[NUM_CNT-1:0];
    ien_nx = ien;
    if (hit(wr_addr, A_IEN_SET)) ien_nx = ien | wr_data[NUM_CNT-1:0];
    if (hit(wr_addr, A_IEN_CLR)) ien_nx = ien & ~wr_data[NUM_CNT-1:0];
    ovf_nx = (ovf_st & ~w1c_mask) | cnt_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en    <= 1'b0;
      long_mode <= 1'b0;
      cen       <= '0;
      ien       <= '0;
      ovf_st    <= '0;
      irq       <= 1'b0;
      for (int i = 0; i < NUM_CNT; i++) src[i] <= EV_EXT;
    end else begin
      if (wr_ctrl) begin
        gen_en    <= wr_data[CTRL_EN_BIT];
        long_mode <= wr_data[CTRL_LONG_BIT];
      end
      if (hit(wr_addr, A_TYPE0)) src[0] <= wr_data[1:0];
      if (hit(wr_addr, A_TYPE1)) src[1] <= wr_data[1:0];
      cen    <= cen_nx;
      ien    <= ien_nx;
      ovf_st <= ovf_nx;
      irq    <= |(ovf_nx & ien_nx);
    end
  end

  evp_readmux #(.CNT_W(CNT_W), .AW(AW)) u_readmux (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .gen_en   (gen_en),
    .long_mode(long_mode),
    .cen      (cen),
    .ien      (ien),
    .ovf_st   (ovf_st),
    .src0     (src[0]),
    .src1     (src[1]),
    .cnt0     (cnt_val[0]),
    .cnt1     (cnt_val[1]),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/evp_checker.sv
module evp_checker
  import evp_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int AW    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic [AW-1:0]      rd_addr,
  input logic [CNT_W-1:0]   rd_data,
  input logic               irq,
  input logic               gen_en,
  input logic               long_mode,
  input logic [NUM_CNT-1:0] ien,
  input logic [NUM_CNT-1:0] ovf_st,
  input logic [1:0]         src1,
  input logic [CNT_W-1:0]   cnt0,
  input logic [CNT_W-1:0]   cnt1
);
  logic wr_ctrl_q, wr_cnt0_q, wr_cnt1_q, w1c0_q;

  always_comb begin
    wr_ctrl_q = wr_en && wr_addr == AW'(A_CTRL);
    wr_cnt0_q = wr_en && wr_addr == AW'(A_CNT0);
    wr_cnt1_q = wr_en && wr_addr == AW'(A_CNT1);
    w1c0_q    = wr_en && wr_addr == AW'(A_OVF) && wr_data[0];
  end

  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(A_CTRL)) |=> (rd_data[6] && rd_data[2:1] == 2'b00 && rd_data[15:11] == 5'd2)); // R2

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl_q && wr_data[1]) |=> (cnt0 == '0 && cnt1 == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!gen_en && !wr_ctrl_q && !wr_cnt0_q) |=> $stable(cnt0)); // R4

  AST_LONG_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (long_mode && src1 == EV_CHAIN && !wr_ctrl_q && !wr_cnt1_q) |=> $stable(cnt1)); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_st[0] && !w1c0_q) |=> ovf_st[0]); // R11

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == |(ovf_st & ien)); // R12
endmodule

bind evt_pair_counter evp_checker #(.CNT_W(CNT_W), .AW(AW)) u_evp_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .irq      (irq),
  .gen_en   (gen_en),
  .long_mode(long_mode),
  .ien      (ien),
  .ovf_st   (ovf_st),
  .src1     (src[1]),
  .cnt0     (cnt_val[0]),
  .cnt1     (cnt_val[1])
);

// File: tb/evt_pair_counter_bench.sv
module evt_pair_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [3:0] R_CTRL = 4'd0, R_CSET = 4'd1, R_CCLR = 4'd2, R_OVF = 4'd3,
                         R_ISET = 4'd4, R_ICLR = 4'd5, R_SWI = 4'd6, R_T0 = 4'd7,
                         R_T1 = 4'd8, R_C0 = 4'd9, R_C1 = 4'd10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [1:0]  evt_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  evt_pair_counter u_evt_pair_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d, input logic [1:0] ev = 2'b00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; evt_in = ev;
    @(negedge clk);
    wr_en = 1'b0; evt_in = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk);
    evt_in = ev;
    @(negedge clk);
    evt_in = 2'b00;
  endtask

  task automatic setup(input logic [63:0] ctrl);
    wr(R_CTRL, ctrl | 64'h2);
    wr(R_OVF, 64'h3);
    wr(R_ICLR, 64'h3);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(R_CTRL, v); chk("R1 ctrl", v, 64'h1040);
    rd(R_C0, v);   chk("R1 cnt0", v, 0);
    rd(R_C1, v);   chk("R1 cnt1", v, 0);
    rd(R_OVF, v);  chk("R1 status", v, 0);
    rd(R_CSET, v); chk("R1 enables", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl();
    logic [63:0] v;
    wr(R_CTRL, 64'hFF);
    rd(R_CTRL, v); chk("R2 ctrl all written", v, 64'h10C1);
    wr(R_CTRL, 64'h0);
    rd(R_CTRL, v); chk("R2 ctrl cleared", v, 64'h1040);
  endtask

  task automatic t_reset_bit();
    logic [63:0] v;
    wr(R_C0, 64'h1234);
    wr(R_C1, 64'h5678);
    wr(R_CTRL, 64'h2);
    rd(R_C0, v); chk("R3 cnt0 zeroed", v, 0);
    rd(R_C1, v); chk("R3 cnt1 zeroed", v, 0);
  endtask

  task automatic t_sw();
    logic [63:0] v;
    setup(64'h0);
    wr(R_T0, 64'h1); wr(R_T1, 64'h0);
    wr(R_CSET, 64'h3);
    wr(R_C0, 64'h5);
    wr(R_SWI, 64'h1);
    rd(R_C0, v); chk("R4 global off", v, 64'h5);
    wr(R_CTRL, 64'h1);
    wr(R_CCLR, 64'h1);
    wr(R_SWI, 64'h1);
    rd(R_C0, v); chk("R4 counter disabled", v, 64'h5);
    rd(R_CSET, v); chk("R14 mask after clear", v, 64'h2);
    wr(R_CSET, 64'h1);
    rd(R_CCLR, v); chk("R14 mask after set", v, 64'h3);
    wr(R_SWI, 64'h1);
    rd(R_C0, v); chk("R4 counted", v, 64'h6);
    wr(R_T0, 64'h0);
    wr(R_SWI, 64'h1);
    rd(R_C0, v); chk("R4 wrong source", v, 64'h6);
  endtask

  task automatic t_ext();
    logic [63:0] v;
    setup(64'h1);
    wr(R_T0, 64'h0); wr(R_T1, 64'h0); wr(R_CSET, 64'h3);
    pulse(2'b01); pulse(2'b11); pulse(2'b01);
    rd(R_C0, v); chk("R5 even pulses", v, 64'h3);
    rd(R_C1, v); chk("R5 odd pulses", v, 64'h1);
  endtask

  task automatic t_ovf32();
    logic [63:0] v;
    setup(64'h1);
    wr(R_T0, 64'h0); wr(R_T1, 64'h3); wr(R_CSET, 64'h3);
    wr(R_C0, 64'hFFFF_FFFF);
    pulse(2'b01);
    rd(R_C0, v); chk("R6 upper bits count", v, 64'h1_0000_0000);
    rd(R_OVF, v); chk("R6 status set", v, 64'h1);
    chk("R12 no irq when disabled", irq, 0);
    wr(R_ISET, 64'h1);
    chk("R12 irq raised", irq, 1);
    wr(R_ICLR, 64'h1);
    chk("R12 irq dropped by enable clear", irq, 0);
    wr(R_ISET, 64'h1);
    wr(R_OVF, 64'h1);
    rd(R_OVF, v); chk("R11 W1C clears", v, 0);
    chk("R12 irq after clear", irq, 0);
  endtask

  task automatic t_ovf64();
    logic [63:0] v;
    setup(64'h81);
    wr(R_T0, 64'h0); wr(R_CSET, 64'h1);
    wr(R_C0, 64'hFFFF_FFFF);
    pulse(2'b01);
    rd(R_C0, v); chk("R7 passes bit31", v, 64'h1_0000_0000);
    rd(R_OVF, v); chk("R7 no status at bit31", v, 0);
    wr(R_C0, ONES);
    pulse(2'b01);
    rd(R_C0, v); chk("R7 wraps", v, 0);
    rd(R_OVF, v); chk("R7 status at bit63", v, 64'h1);
  endtask

  task automatic t_chain();
    logic [63:0] v;
    setup(64'h1);
    wr(R_T0, 64'h0); wr(R_T1, 64'h2); wr(R_CSET, 64'h3);
    wr(R_C0, 64'hFFFF_FFFF); wr(R_C1, 64'h1);
    pulse(2'b01);
    rd(R_C1, v); chk("R8 chained 1 to 2", v, 64'h2);
    rd(R_OVF, v); chk("R8 even status", v, 64'h1);
    wr(R_OVF, 64'h3);
    wr(R_C0, 64'hFFFF_FFFF); wr(R_C1, ONES);
    pulse(2'b01);
    rd(R_C1, v); chk("R9 odd wrapped", v, 0);
    rd(R_OVF, v); chk("R9 both status", v, 64'h3);
  endtask

  task automatic t_long_chain();
    logic [63:0] v;
    setup(64'h81);
    wr(R_T0, 64'h0); wr(R_T1, 64'h2); wr(R_CSET, 64'h3);
    wr(R_C0, ONES); wr(R_C1, 64'h55);
    pulse(2'b01);
    rd(R_C0, v); chk("R10 even wrapped", v, 0);
    rd(R_C1, v); chk("R10 odd held", v, 64'h55);
    rd(R_OVF, v); chk("R10 status even only", v, 64'h1);
  endtask

  task automatic t_prio();
    logic [63:0] v;
    setup(64'h1);
    wr(R_T0, 64'h0); wr(R_T1, 64'h3); wr(R_CSET, 64'h1);
    wr(R_C0, 64'h7);
    wr(R_C0, 64'h100, 2'b01);
    rd(R_C0, v); chk("R13 write beats event", v, 64'h100);
    wr(R_C0, 64'hFFFF_FFFF);
    pulse(2'b01);
    wr(R_C0, 64'hFFFF_FFFF);
    wr(R_OVF, 64'h1, 2'b01);
    rd(R_OVF, v); chk("R11 new overflow beats clear", v, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_reset_bit();
    t_sw();
    t_ext();
    t_ovf32();
    t_ovf64();
    t_chain();
    t_long_chain();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule